// File: doc/BRIEF.md
# Streaming write allocation detector

This block observes the write requests that reach a cache and decides, from the shape of the recent write stream, how the cache should treat the next miss. The cache can allocate a line on a write miss, gather sequential writes into whole-line writes, or stop allocating and let a long stream bypass the cache. The decision rests on two pieces of state. One is the address the next write would have if the stream continued without a gap. The other is a running count of contiguous bytes, which is compared against two configured thresholds.

The block also keeps a small direct-mapped, tagged table of hold-off counters, one slot per low block-address value. Each sequential write rearms the counter for its block. The cache can then ask, for any block, whether a pending write there should be held back for another cycle so that later writes can join it. Every query that answers yes uses up one unit of that block's counter.

Top module: `wr_stream_classifier`

## Requirements
- R1: After reset the mode is allocate, the expected next address is 0, and every hold-off slot is empty, so a query for any block returns 0.
- R2: `mode_o` encodes allocate as 0, coalesce as 1 and bypass as 2, and never takes the value 3. `alloc_o` is 1 unless the mode is bypass. `coal_o` is 1 unless the mode is allocate.
- R3: A write is sequential only when its address equals the stored expected address exactly. After every accepted write, the expected address becomes the write address plus the write size in bytes.
- R4: A sequential write in allocate or coalesce mode adds its size to the byte count. In allocate mode, the mode becomes coalesce when the new count is strictly greater than `COAL_LIMIT`.
- R5: In coalesce mode, a sequential write moves the mode to bypass when the new count is strictly greater than `BYPASS_LIMIT`. A sequential write in bypass mode leaves both the mode and the count unchanged. Bypass is entered only from coalesce.
- R6: A non-sequential write sets the byte count to that write's size and the mode to allocate. It causes no threshold transition in the same write, even when its size exceeds a limit.
- R7: A sequential write stores its block's tag in the slot selected by the low `IDX_W` block-address bits and loads that slot's counter with `HOLD_THRESH`. The block address is the write address shifted right by `BLK_OFS_W`.
- R8: `dq_hold_o` is 1 in the same cycle as `dq_vld_i` when the queried block's tag matches its slot and the slot's counter is non-zero. In that case the counter decrements by one at the clock edge. Otherwise `dq_hold_o` is 0.
- R9: A non-sequential write clears the counter of its block's slot, so a later query for that block returns 0.
- R10: A query for a block whose slot holds a different tag returns 0 and leaves that slot unchanged.
- R11: When a write and a query select the same slot in the same cycle, the write's rearm or clear takes effect and the decrement is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_vld_i | input | 1 | A write is observed this cycle |
| wr_addr_i | input | ADDR_W | Byte address of the observed write |
| wr_size_i | input | SIZE_W | Size of the observed write in bytes |
| dq_vld_i | input | 1 | Hold-off query strobe |
| dq_blk_i | input | ADDR_W-BLK_OFS_W | Block address being queried |
| dq_hold_o | output | 1 | Hold the queried block's write (combinational answer) |
| mode_o | output | 2 | Current mode: 0 allocate, 1 coalesce, 2 bypass |
| alloc_o | output | 1 | Allocate on write miss |
| coal_o | output | 1 | Coalesce writes into whole lines |

## Verification
The hardest state to reach is bypass, because the bench must build one unbroken run whose byte count crosses both limits. Any gap, or any write that lands one byte off the expected address, silently restarts the count. The directed ramp issues line-sized writes from a fresh non-sequential start and checks the mode after each one, so each limit is seen both when the count sits exactly at it and when it goes past. Aliasing in the hold-off table is reached by querying a block whose low address bits match an armed block but whose tag differs. The armed block is then queried again to show that its budget was not touched.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [1:0] {
    WM_ALLOC  = 2'd0,
    WM_COAL   = 2'd1,
    WM_BYPASS = 2'd2
  } wr_mode_e;
endpackage

// File: rtl/wsc_mode_fsm.sv
module wsc_mode_fsm
  import wsc_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SIZE_W       = 8,
  parameter int BYTE_W       = 16,
  parameter int COAL_LIMIT   = 128,
  parameter int BYPASS_LIMIT = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_vld_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  output logic              seq_o,
  output wr_mode_e          mode_o
);
  localparam logic [BYTE_W-1:0] COAL_LIM_C   = BYTE_W'(COAL_LIMIT);
  localparam logic [BYTE_W-1:0] BYPASS_LIM_C = BYTE_W'(BYPASS_LIMIT);
  localparam logic [BYTE_W-1:0] CNT_MAX      = '1;

  logic [ADDR_W-1:0] next_addr_q;
  logic [BYTE_W-1:0] cnt_q, cnt_d;
  wr_mode_e          mode_q, mode_d;
  logic [BYTE_W:0]   sum;
  logic [BYTE_W-1:0] sum_sat;

  assign seq_o   = (wr_addr_i == next_addr_q);
  assign sum     = {1'b0, cnt_q} + (BYTE_W+1)'(wr_size_i);
  assign sum_sat = sum[BYTE_W] ? CNT_MAX : sum[BYTE_W-1:0];

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (wr_vld_i) begin
      if (seq_o) begin
        if (mode_q != WM_BYPASS) begin
          cnt_d = sum_sat;
          if (mode_q == WM_ALLOC && sum_sat > COAL_LIM_C)
            mode_d = WM_COAL;
          else if (mode_q == WM_COAL && sum_sat > BYPASS_LIM_C)
            mode_d = WM_BYPASS;
        end
      end else begin
        cnt_d  = BYTE_W'(wr_size_i);
        mode_d = WM_ALLOC;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_addr_q <= '0;
      cnt_q       <= '0;
      mode_q      <= WM_ALLOC;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      if (wr_vld_i) next_addr_q <= wr_addr_i + ADDR_W'(wr_size_i);
    end
  end

  assign mode_o = mode_q;

  p_next_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_i |=> next_addr_q == $past(wr_addr_i + ADDR_W'(wr_size_i)));
  p_nonseq_alloc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_i && !seq_o) |=> (mode_q == WM_ALLOC && cnt_q == BYTE_W'($past(wr_size_i))));
  p_bypass_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_i && seq_o && mode_q == WM_BYPASS) |=> (mode_q == WM_BYPASS && $stable(cnt_q)));
  p_bypass_from_coal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != WM_BYPASS) ##1 (mode_q == WM_BYPASS) |-> $past(mode_q) == WM_COAL);
endmodule

// File: rtl/wsc_hold_table.sv
module wsc_hold_table #(
  parameter int BLK_W       = 26,
  parameter int IDX_W       = 3,
  parameter int HOLD_W      = 4,
  parameter int HOLD_THRESH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_vld_i,
  input  logic             arm_seq_i,
  input  logic [BLK_W-1:0] arm_blk_i,
  input  logic             q_vld_i,
  input  logic [BLK_W-1:0] q_blk_i,
  output logic             q_hold_o
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = BLK_W - IDX_W;
  localparam logic [HOLD_W-1:0] HOLD_C = HOLD_W'(HOLD_THRESH);

  logic [TAG_W-1:0]  tag_q [ENTRIES];
  logic [HOLD_W-1:0] cnt_q [ENTRIES];

  logic [IDX_W-1:0] arm_idx, q_idx;
  logic [TAG_W-1:0] arm_tag, q_tag;
  logic             q_hit, q_take;

  assign arm_idx = arm_blk_i[IDX_W-1:0];
  assign arm_tag = arm_blk_i[BLK_W-1:IDX_W];
  assign q_idx   = q_blk_i[IDX_W-1:0];
  assign q_tag   = q_blk_i[BLK_W-1:IDX_W];

  assign q_hit  = q_vld_i && (tag_q[q_idx] == q_tag) && (cnt_q[q_idx] != '0);
  // a same-slot write overrides the decrement
  assign q_take = q_hit && !(arm_vld_i && arm_idx == q_idx);
  assign q_hold_o = q_hit;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[e] <= '0;
        cnt_q[e] <= '0;
      end else if (arm_vld_i && arm_idx == IDX_W'(e)) begin
        tag_q[e] <= arm_tag;
        cnt_q[e] <= arm_seq_i ? HOLD_C : '0;
      end else if (q_take && q_idx == IDX_W'(e)) begin
        cnt_q[e] <= cnt_q[e] - 1'b1;
      end
    end

    p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q[e] <= HOLD_C);
  end

  p_arm_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_vld_i && arm_seq_i) |=> cnt_q[$past(arm_idx)] == HOLD_C);
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_vld_i && !arm_seq_i) |=> cnt_q[$past(arm_idx)] == '0);
  p_query_dec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_take |=> cnt_q[$past(q_idx)] == $past(cnt_q[q_idx]) - 1'b1);
  p_miss_untouched_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_vld_i && !q_hit && !(arm_vld_i && arm_idx == q_idx))
      |=> $stable(cnt_q[$past(q_idx)]));
endmodule

// File: rtl/wr_stream_classifier.sv
module wr_stream_classifier
  import wsc_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SIZE_W       = 8,
  parameter int BYTE_W       = 16,
  parameter int BLK_OFS_W    = 6,
  parameter int IDX_W        = 3,
  parameter int HOLD_W       = 4,
  parameter int HOLD_THRESH  = 3,
  parameter int COAL_LIMIT   = 128,
  parameter int BYPASS_LIMIT = 512,
  localparam int BLK_W       = ADDR_W - BLK_OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_vld_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  input  logic              dq_vld_i,
  input  logic [BLK_W-1:0]  dq_blk_i,
  output logic              dq_hold_o,
  output logic [1:0]        mode_o,
  output logic              alloc_o,
  output logic              coal_o
);
  logic     seq;
  wr_mode_e mode;

  wsc_mode_fsm #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BYTE_W(BYTE_W),
    .COAL_LIMIT(COAL_LIMIT), .BYPASS_LIMIT(BYPASS_LIMIT)
  ) u_fsm (
    .clk_i, .rst_ni, .wr_vld_i, .wr_addr_i, .wr_size_i,
    .seq_o(seq), .mode_o(mode)
  );

  wsc_hold_table #(
    .BLK_W(BLK_W), .IDX_W(IDX_W), .HOLD_W(HOLD_W), .HOLD_THRESH(HOLD_THRESH)
  ) u_tbl (
    .clk_i, .rst_ni,
    .arm_vld_i(wr_vld_i), .arm_seq_i(seq),
    .arm_blk_i(wr_addr_i[ADDR_W-1:BLK_OFS_W]),
    .q_vld_i(dq_vld_i), .q_blk_i(dq_blk_i), .q_hold_o(dq_hold_o)
  );

  assign mode_o  = mode;
  assign alloc_o = (mode != WM_BYPASS);
  assign coal_o  = (mode != WM_ALLOC);

  p_mode_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);
  p_hold_needs_query_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_hold_o |-> dq_vld_i);
endmodule

// File: tb/sim_wr_stream_classifier.sv
`timescale 1ns/1ps
module sim_wr_stream_classifier;
  localparam int ADDR_W = 32;
  localparam int BLK_W  = 26;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_vld_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [7:0]        wr_size_i = '0;
  logic              dq_vld_i = 1'b0;
  logic [BLK_W-1:0]  dq_blk_i = '0;
  logic              dq_hold_o;
  logic [1:0]        mode_o;
  logic              alloc_o, coal_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wr_stream_classifier u0 (
    .clk_i(clk), .rst_ni, .wr_vld_i, .wr_addr_i, .wr_size_i,
    .dq_vld_i, .dq_blk_i, .dq_hold_o, .mode_o, .alloc_o, .coal_o
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_mode(input string req, input int m);
    check({req, " mode"}, mode_o, m);
    check({req, " alloc"}, alloc_o, m != 2);
    check({req, " coal"}, coal_o, m != 0);
  endtask

  task automatic do_write(input logic [31:0] a, input logic [7:0] s);
    @(negedge clk);
    wr_vld_i = 1'b1; wr_addr_i = a; wr_size_i = s;
    @(negedge clk);
    wr_vld_i = 1'b0;
  endtask

  task automatic do_query(input logic [BLK_W-1:0] b, output logic h);
    @(negedge clk);
    dq_vld_i = 1'b1; dq_blk_i = b;
    #1 h = dq_hold_o;
    @(negedge clk);
    dq_vld_i = 1'b0;
  endtask

  task automatic t_reset();
    logic h;
    check_mode("R1 reset", 0);
    do_query(26'h0, h);
    check("R1 empty slot", h, 0);
  endtask

  task automatic t_ramp();
    do_write(32'h1000, 8'd64);
    check_mode("R3 nonseq start", 0);
    do_write(32'h1040, 8'd64);
    check_mode("R4 count at limit", 0);
    do_write(32'h1080, 8'd64);
    check_mode("R4 past coal limit", 1);
    for (int i = 0; i < 4; i++) begin
      do_write(32'h10C0 + i * 64, 8'd64);
      check_mode("R5 below bypass limit", 1);
    end
    do_write(32'h11C0, 8'd64);
    check_mode("R5 count at bypass limit", 1);
    do_write(32'h1200, 8'd64);
    check_mode("R5 past bypass limit", 2);
  endtask

  task automatic t_hold();
    logic h;
    for (int i = 0; i < 3; i++) begin
      do_query(26'h48, h);
      check("R8 hold budget", h, 1);
    end
    do_query(26'h48, h);
    check("R8 budget exhausted", h, 0);
    do_query(26'h47, h);
    check("R7 earlier block armed", h, 1);
    do_query(26'h4F, h);
    check("R10 alias miss", h, 0);
    do_query(26'h4F, h);
    check("R10 alias miss again", h, 0);
    do_query(26'h47, h);
    check("R10 entry kept", h, 1);
    do_query(26'h47, h);
    check("R10 entry kept last", h, 1);
    do_query(26'h47, h);
    check("R8 empty after use", h, 0);
  endtask

  task automatic t_nonseq_clear();
    logic h;
    do_write(32'h1240, 8'd64);
    check_mode("R5 seq in bypass", 2);
    do_write(32'h1248, 8'd8);
    check_mode("R6 nonseq returns", 0);
    do_query(26'h49, h);
    check("R9 cleared slot", h, 0);
    do_write(32'h1251, 8'd8);
    do_query(26'h49, h);
    check("R3 off by one not seq", h, 0);
  endtask

  task automatic t_big_nonseq();
    do_write(32'h9000, 8'd200);
    check_mode("R6 large nonseq no jump", 0);
    do_write(32'h90C8, 8'd1);
    check_mode("R6 count restarted at size", 1);
    do_write(32'h90C9, 8'd255);
    check_mode("R5 accumulate in coal", 1);
    do_write(32'h91C8, 8'd60);
    check_mode("R5 crosses bypass", 2);
  endtask

  task automatic t_collide();
    logic h;
    do_write(32'hA000, 8'd4);
    do_write(32'hA004, 8'd4);
    do_query(26'h280, h);
    check("R7 armed before collision", h, 1);
    @(negedge clk);
    wr_vld_i = 1'b1; wr_addr_i = 32'hA008; wr_size_i = 8'd4;
    dq_vld_i = 1'b1; dq_blk_i = 26'h280;
    #1 check("R11 answer during write", dq_hold_o, 1);
    @(negedge clk);
    wr_vld_i = 1'b0; dq_vld_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      do_query(26'h280, h);
      check("R11 rearm wins", h, 1);
    end
    do_query(26'h280, h);
    check("R11 budget then empty", h, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_ramp();
    t_hold();
    t_nonseq_clear();
    t_big_nonseq();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule